// File: doc/BRIEF.md
# Per-Bucket Bunch Current Averager

This block turns a stream of digitized pickup samples into one averaged current figure per bucket of a storage ring. Each bucket contributes four consecutive samples per turn, taken at four phase points of the downconverted signal. The block removes a programmable pedestal from each phase and forms a cosine and a sine component. It then estimates their quadrature magnitude without a square root and adds it to a per-bucket accumulator. Only one turn in every eight is used. After 250 used turns the accumulator is divided by 250, the quotient is stored in a result buffer and the accumulator restarts from zero.

One instance covers a contiguous slice of the ring, for example a twelfth of it. The number of buckets is a parameter. A sequencer state machine tracks where the stream stands and has three states. `ST_IDLE` means no turn marker has been seen since reset. `ST_ACC` means the current turn is being accumulated. `ST_SKIP` means the current turn is ignored, or its in-range buckets are already done. The sequencer makes these transitions:
- `ST_IDLE` goes to `ST_ACC` on the first marked sample.
- `ST_SKIP` goes to `ST_ACC` on a marker whose turn index wraps to zero.
- `ST_SKIP` and `ST_ACC` go to `ST_SKIP` on a marker with a non-zero turn index.
- `ST_ACC` goes to `ST_SKIP` after the fourth sample of the last bucket.

A host reads finished averages through a request/response port with a one-entry response register.

Top module: `bunch_avg`

## Requirements
- R1: After reset no response is pending, `rd_ready` is high, and every bucket reads back 0.
- R2: Samples that arrive before the first marked sample after reset have no effect on any result.
- R3: A marked sample (`s_valid` and `s_turn` high) starts a turn. Counting it as position 0, the samples at positions 4k to 4k+3 belong to bucket k, in the phase order +cos, -cos, +sin, -sin.
- R4: The first marked turn after reset has index 0. Only turns whose index is a multiple of 8 contribute; samples of every other turn have no effect.
- R5: Four pedestal registers reset to 0 and are written with `ped_we`. `ped_sel` chooses the phase: 0 = +cos, 1 = -cos, 2 = +sin, 3 = -sin. Each sample has the pedestal of its phase subtracted. A write takes effect for samples from the next cycle on.
- R6: The cosine part is C = (+cos − ped0) − (−cos − ped1) and the sine part is S = (+sin − ped2) − (−sin − ped3). The per-turn amplitude is max(|C|,|S|) + floor(min(|C|,|S|)/2).
- R7: When a bucket's 250th contributing turn completes, its result becomes floor(sum of the 250 amplitudes / 250) and its accumulator restarts from zero. The result holds that value until the bucket's next 250-turn window completes.
- R8: Samples beyond the last bucket of the slice, up to the next marker, have no effect.
- R9: A read request is accepted when `rd_req` and `rd_ready` are high. In the next cycle `rsp_valid` rises with the bucket's result, or 0 if the index is not below the bucket count. The response holds stable while `rsp_ready` is low, and `rd_ready` is low during that time.
- R10: Cycles with `s_valid` low neither advance the sample position nor change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_turn | input | 1 | Sample is the first of a turn |
| s_data | input | SW | Unsigned sample value |
| ped_we | input | 1 | Pedestal write strobe |
| ped_sel | input | 2 | Pedestal phase select |
| ped_wdata | input | SW | Pedestal value |
| rd_req | input | 1 | Read request valid |
| rd_bucket | input | clog2(NB)+1 | Bucket index to read |
| rd_ready | output | 1 | Read request can be accepted |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | SW+2 | Averaged amplitude of the requested bucket |
| rsp_ready | input | 1 | Response consumer ready |

## Verification
A wrong sequencer state or a wrong bucket/phase position shows up as a corrupted average. This happens only when a window of 250 used turns completes, which is 2000 turns after the fault. The per-clock reference model therefore catches it at the first read after that boundary. An accumulator that is not cleared shows as a doubled value after the second window. A wrong response-register state shows at the ports in the very next cycle, as `rsp_valid`, `rsp_data` or `rd_ready` disagreeing with the model.

// File: rtl/bca_pkg.sv
package bca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SKIP = 2'd1,
        ST_ACC  = 2'd2
    } seq_state_t;

    localparam logic [1:0] PH_PCOS = 2'd0;
    localparam logic [1:0] PH_MCOS = 2'd1;
    localparam logic [1:0] PH_PSIN = 2'd2;
    localparam logic [1:0] PH_MSIN = 2'd3;
endpackage

// File: rtl/bca_seq.sv
module bca_seq
    import bca_pkg::*;
#(
    parameter int NB       = 12,
    parameter int TURN_DIV = 8,
    parameter int NAVG     = 250,
    parameter int BW       = 4,
    parameter int TW       = 3,
    parameter int WW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic          s_turn,
    output logic          take,
    output logic [1:0]    phase,
    output logic [BW-1:0] bkt,
    output logic          win_last
);
    seq_state_t    state_q, state_d;
    logic [TW-1:0] turn_q, new_turn;
    logic [1:0]    ph_q;
    logic [BW-1:0] bkt_q;
    logic [WW-1:0] win_q;
    logic          marker, row_end;

    // Output and decode process
    always_comb begin
        marker   = s_valid && s_turn;
        new_turn = (state_q == ST_IDLE || turn_q == TW'(TURN_DIV - 1)) ? '0 : turn_q + 1'b1;
        phase    = s_turn ? PH_PCOS : ph_q;
        bkt      = s_turn ? '0 : bkt_q;
        take     = s_valid && (s_turn ? (new_turn == '0) : (state_q == ST_ACC));
        row_end  = take && phase == PH_MSIN && bkt == BW'(NB - 1);
        win_last = (win_q == WW'(NAVG - 1));
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (marker) state_d = ST_ACC;
            ST_SKIP: if (marker) state_d = (new_turn == '0) ? ST_ACC : ST_SKIP;
            ST_ACC: begin
                if (marker)       state_d = (new_turn == '0) ? ST_ACC : ST_SKIP;
                else if (row_end) state_d = ST_SKIP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= '0;
            ph_q   <= '0;
            bkt_q  <= '0;
            win_q  <= '0;
        end else begin
            if (marker) turn_q <= new_turn;
            if (take) begin
                ph_q  <= phase + 2'd1;
                bkt_q <= (phase == PH_MSIN) ? bkt + 1'b1 : bkt;
            end
            if (row_end) win_q <= win_last ? '0 : win_q + 1'b1;
        end
    end
endmodule

// File: rtl/bca_quad.sv
module bca_quad
    import bca_pkg::*;
#(
    parameter int SW = 12,
    parameter int MW = SW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ped_we,
    input  logic [1:0]    ped_sel,
    input  logic [SW-1:0] ped_wdata,
    input  logic          take,
    input  logic [1:0]    phase,
    input  logic [SW-1:0] sample,
    output logic [MW-1:0] mag
);
    logic [SW-1:0] ped_q [4];
    logic [SW-1:0] cap_pc, cap_mc, cap_ps;
    logic signed [MW-1:0] c_val, s_val;
    logic [MW-1:0] c_abs, s_abs;

    function automatic logic signed [MW-1:0] rel(input logic [SW-1:0] x, input logic [SW-1:0] p);
        return $signed({2'b00, x}) - $signed({2'b00, p});
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) ped_q[i] <= '0;
        end else if (ped_we) begin
            ped_q[ped_sel] <= ped_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pc <= '0;
            cap_mc <= '0;
            cap_ps <= '0;
        end else if (take) begin
            unique case (phase)
                PH_PCOS: cap_pc <= sample;
                PH_MCOS: cap_mc <= sample;
                PH_PSIN: cap_ps <= sample;
                default: ;
            endcase
        end
    end

    always_comb begin
        c_val = rel(cap_pc, ped_q[0]) - rel(cap_mc, ped_q[1]);
        s_val = rel(cap_ps, ped_q[2]) - rel(sample, ped_q[3]);
        c_abs = c_val[MW-1] ? MW'(-c_val) : MW'(c_val);
        s_abs = s_val[MW-1] ? MW'(-s_val) : MW'(s_val);
        mag   = (c_abs >= s_abs) ? c_abs + (s_abs >> 1) : s_abs + (c_abs >> 1);
    end
endmodule

// File: rtl/bca_store.sv
module bca_store #(
    parameter int NB   = 12,
    parameter int MW   = 14,
    parameter int NAVG = 250,
    parameter int BW   = 4,
    parameter int RBW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [BW-1:0]  wr_bkt,
    input  logic           wr_last,
    input  logic [MW-1:0]  mag,
    input  logic           rd_req,
    input  logic [RBW-1:0] rd_bucket,
    output logic           rd_ready,
    output logic           rsp_valid,
    output logic [MW-1:0]  rsp_data,
    input  logic           rsp_ready
);
    localparam int AW = MW + $clog2(NAVG) + 1;
    localparam logic [AW-1:0] NAVG_W = AW'(NAVG);

    logic [AW-1:0] acc_q [NB];
    logic [MW-1:0] res_q [NB];
    logic [AW-1:0] sum;
    logic          rd_in_range;
    logic [BW-1:0] rd_idx;

    always_comb begin
        sum         = acc_q[wr_bkt] + AW'(mag);
        rd_ready    = !rsp_valid || rsp_ready;
        rd_in_range = rd_bucket < RBW'(NB);
        rd_idx      = BW'(rd_bucket);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                acc_q[i] <= '0;
                res_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_last) begin
                res_q[wr_bkt] <= MW'(sum / NAVG_W);
                acc_q[wr_bkt] <= '0;
            end else begin
                acc_q[wr_bkt] <= sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (rd_req && rd_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_in_range ? res_q[rd_idx] : '0;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bunch_avg.sv
module bunch_avg
    import bca_pkg::*;
#(
    parameter int SW       = 12,
    parameter int NB       = 12,
    parameter int NAVG     = 250,
    parameter int TURN_DIV = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic                 s_turn,
    input  logic [SW-1:0]        s_data,
    input  logic                 ped_we,
    input  logic [1:0]           ped_sel,
    input  logic [SW-1:0]        ped_wdata,
    input  logic                 rd_req,
    input  logic [$clog2(NB):0]  rd_bucket,
    output logic                 rd_ready,
    output logic                 rsp_valid,
    output logic [SW+1:0]        rsp_data,
    input  logic                 rsp_ready
);
    localparam int BW  = $clog2(NB);
    localparam int RBW = BW + 1;
    localparam int MW  = SW + 2;
    localparam int TW  = $clog2(TURN_DIV);
    localparam int WW  = $clog2(NAVG);

    logic          seq_take, seq_wlast;
    logic [1:0]    seq_phase;
    logic [BW-1:0] seq_bkt;
    logic [MW-1:0] q_mag;
    logic          wr_en;

    bca_seq #(.NB(NB), .TURN_DIV(TURN_DIV), .NAVG(NAVG), .BW(BW), .TW(TW), .WW(WW)) u_seq (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_turn(s_turn),
        .take(seq_take), .phase(seq_phase), .bkt(seq_bkt), .win_last(seq_wlast)
    );

    bca_quad #(.SW(SW), .MW(MW)) u_quad (
        .clk(clk), .rst_n(rst_n), .ped_we(ped_we), .ped_sel(ped_sel), .ped_wdata(ped_wdata),
        .take(seq_take), .phase(seq_phase), .sample(s_data), .mag(q_mag)
    );

    assign wr_en = seq_take && seq_phase == PH_MSIN;

    bca_store #(.NB(NB), .MW(MW), .NAVG(NAVG), .BW(BW), .RBW(RBW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bkt(seq_bkt), .wr_last(seq_wlast),
        .mag(q_mag), .rd_req(rd_req), .rd_bucket(rd_bucket), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
    );
endmodule

// File: rtl/bunch_avg_chk.sv
module bunch_avg_chk #(
    parameter int NB = 12,
    parameter int BW = 4,
    parameter int TW = 3,
    parameter int MW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          take,
    input logic          s_turn,
    input logic [BW-1:0] bkt,
    input logic [TW-1:0] turn_idx,
    input logic          rd_req,
    input logic          rd_ready,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [MW-1:0] rsp_data
);
    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsp_valid);

    // R8
    bkt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> int'(bkt) < NB);

    // R4
    turn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !s_turn) |-> turn_idx == '0);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9
    rd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> rsp_valid);
endmodule

bind bunch_avg bunch_avg_chk #(.NB(NB), .BW(BW), .TW(TW), .MW(MW)) u_chk (
    .clk(clk), .rst_n(rst_n), .take(seq_take), .s_turn(s_turn), .bkt(seq_bkt),
    .turn_idx(u_seq.turn_q), .rd_req(rd_req), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/tb_bunch_avg.sv
module tb_bunch_avg;
    localparam int CLK_PERIOD = 10;
    localparam int SW   = 12;
    localparam int NB   = 4;
    localparam int NAVG = 250;
    localparam int TDIV = 8;
    localparam int MW   = SW + 2;
    localparam int RBW  = $clog2(NB) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           s_valid = 1'b0, s_turn = 1'b0;
    logic [SW-1:0]  s_data = '0;
    logic           ped_we = 1'b0;
    logic [1:0]     ped_sel = '0;
    logic [SW-1:0]  ped_wdata = '0;
    logic           rd_req = 1'b0;
    logic [RBW-1:0] rd_bucket = '0;
    logic           rd_ready, rsp_valid;
    logic [MW-1:0]  rsp_data;
    logic           rsp_ready = 1'b1;

    int n_chk = 0, n_fail = 0;

    bunch_avg #(.SW(SW), .NB(NB), .NAVG(NAVG), .TURN_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_turn(s_turn), .s_data(s_data),
        .ped_we(ped_we), .ped_sel(ped_sel), .ped_wdata(ped_wdata),
        .rd_req(rd_req), .rd_bucket(rd_bucket), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_turn, m_pos, m_win;
    int m_acc [NB];
    int m_res [NB];
    int m_cap [4];
    int m_ped [4];
    bit e_vld;
    int e_data;
    int ph, bi, cc, ss, ac, as, mg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_turn = -1; m_pos = 0; m_win = 0; e_vld = 0; e_data = 0;
            for (int i = 0; i < NB; i++) begin m_acc[i] = 0; m_res[i] = 0; end
            for (int i = 0; i < 4; i++) begin m_cap[i] = 0; m_ped[i] = 0; end
        end else begin
            if (rd_req && (!e_vld || rsp_ready)) begin
                e_vld = 1;
                e_data = (int'(rd_bucket) < NB) ? m_res[rd_bucket] : 0;
            end else if (rsp_ready) begin
                e_vld = 0;
            end
            if (s_valid) begin
                if (s_turn) begin
                    m_turn = (m_turn < 0) ? 0 : m_turn + 1;
                    m_pos = 0;
                end else if (m_turn >= 0) begin
                    m_pos++;
                end
                if (m_turn >= 0 && m_turn % TDIV == 0 && m_pos < 4*NB) begin
                    ph = m_pos % 4; bi = m_pos / 4;
                    m_cap[ph] = int'(s_data);
                    if (ph == 3) begin
                        cc = (m_cap[0] - m_ped[0]) - (m_cap[1] - m_ped[1]);
                        ss = (m_cap[2] - m_ped[2]) - (m_cap[3] - m_ped[3]);
                        ac = cc < 0 ? -cc : cc;
                        as = ss < 0 ? -ss : ss;
                        mg = (ac >= as) ? ac + as/2 : as + ac/2;
                        m_acc[bi] += mg;
                        if (m_win == NAVG-1) begin
                            m_res[bi] = m_acc[bi] / NAVG;
                            m_acc[bi] = 0;
                        end
                        if (bi == NB-1) m_win = (m_win + 1) % NAVG;
                    end
                end
            end
            if (ped_we) m_ped[ped_sel] = int'(ped_wdata);
        end
    end

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(rsp_valid == e_vld, "R9 rsp_valid vs model", int'(rsp_valid), int'(e_vld));
            if (e_vld) check(int'(rsp_data) == e_data, "R7 rsp_data vs model", int'(rsp_data), e_data);
        end
    end

    // Stimulus
    int tb_ped [4];
    int cv [NB] = '{300, -200, 40, 0};
    int sv [NB] = '{100, 150, -41, 0};

    task automatic send(input bit v, input bit t, input int d);
        @(negedge clk);
        s_valid = v; s_turn = t; s_data = d[SW-1:0];
    endtask

    task automatic ped_write(input int sel, input int val);
        @(negedge clk);
        s_valid = 0; s_turn = 0;
        ped_we = 1; ped_sel = sel[1:0]; ped_wdata = val[SW-1:0];
        tb_ped[sel] = val;
        @(negedge clk);
        ped_we = 0;
    endtask

    task automatic do_read(input int b, input int exp, input string tag);
        @(negedge clk);
        s_valid = 0; s_turn = 0;
        rd_req = 1; rd_bucket = b[RBW-1:0];
        @(negedge clk);
        rd_req = 0;
        check(rsp_valid == 1'b1, tag, int'(rsp_valid), 1);
        check(int'(rsp_data) == exp, tag, int'(rsp_data), exp);
    endtask

    task automatic run_turn(input int t, input bit w2);
        int cval;
        for (int b = 0; b < NB; b++) begin
            if (t % TDIV == 0) begin
                cval = cv[b] + ((w2 && b == 0) ? ((t - 2000) / TDIV) % 2 : 0);
                send(1, b == 0, tb_ped[0] + 1000 + cval);
                send(1, 0, tb_ped[1] + 1000);
                send(1, 0, tb_ped[2] + 1000 + sv[b]);
                send(1, 0, tb_ped[3] + 1000);
            end else begin
                send(1, b == 0, 4095);
                send(1, 0, 0);
                send(1, 0, 4095);
                send(1, 0, 0);
            end
            if (b == 1) send(0, 0, 4095);  // R10 gap cycle
        end
        for (int e = 0; e < 4; e++) send(1, 0, 4095);  // R8 samples past the slice
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tb_ped[i] = 0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
        check(rd_ready == 1'b1, "R1 rd_ready in reset", int'(rd_ready), 1);
        rst_n = 1;
        do_read(2, 0, "R1 result after reset");

        ped_write(0, 10); ped_write(1, 20); ped_write(2, 30); ped_write(3, 40);

        for (int i = 0; i < 8; i++) send(1, 0, 4095);  // R2 before any marker

        for (int t = 0; t < 2000; t++) begin
            run_turn(t, 0);
            if (t == 1000) do_read(0, 0, "R7 no result before window completes");
        end
        do_read(0, 350, "R6 bucket0 amplitude");
        do_read(1, 275, "R3 R6 bucket1 negative cosine");
        do_read(2, 61, "R6 bucket2 sine dominant with floor");
        do_read(3, 0, "R2 R4 R8 R10 ignored samples leave bucket3 zero");
        do_read(5, 0, "R9 out-of-range index");

        // R9 back-pressure
        @(negedge clk);
        s_valid = 0; rsp_ready = 0; rd_req = 1; rd_bucket = 1;
        @(negedge clk);
        rd_req = 0;
        check(rsp_valid == 1'b1, "R9 stalled response valid", int'(rsp_valid), 1);
        check(rd_ready == 1'b0, "R9 rd_ready low while stalled", int'(rd_ready), 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R9 response held", int'(rsp_valid), 1);
        check(int'(rsp_data) == 275, "R9 held data", int'(rsp_data), 275);
        check(rd_ready == 1'b0, "R9 rd_ready still low", int'(rd_ready), 0);
        rsp_ready = 1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 response released", int'(rsp_valid), 0);
        check(rd_ready == 1'b1, "R9 rd_ready restored", int'(rd_ready), 1);

        ped_write(0, 200); ped_write(1, 5); ped_write(2, 77); ped_write(3, 300);

        for (int t = 2000; t < 4000; t++) begin
            run_turn(t, 1);
            if (t == 3000) do_read(0, 350, "R7 previous result held mid-window");
        end
        do_read(0, 350, "R7 floor of 350.5 average");
        do_read(1, 275, "R5 new pedestals bucket1");
        do_read(2, 61, "R5 new pedestals bucket2");
        do_read(3, 0, "R7 accumulator restarted");
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_up();
    end
endmodule